// File: doc/BRIEF.md
# Dual Wiper Register Bank with Non-Volatile Shadow Storage

This block is the register bank that sits behind a serial slave interface in a two-channel digital potentiometer. It keeps a volatile 7-bit code for each wiper, a non-volatile initial value for each wiper, five non-volatile general-purpose bytes, a reserved location and a control register. A single mode bit in the control register decides whether an access to a wiper address reaches the volatile code or its non-volatile copy. Non-volatile storage is modelled as a small array inside the block. A counter stands in for the self-timed programming cycle, which starts only when the transaction ends.

The block also runs the power-up sequence. While supply is not good, both wipers sit at mid-scale (40h) and the access ports are closed. Once supply is good, the wipers are loaded from their initial values and the ports open. Each channel has a shutdown flag, driven from the control register and a shutdown pin. During shutdown the wiper codes are kept, so the same settings come back when shutdown ends.

Writes and reads use valid/ready. A request is taken on a clock edge where valid and ready are both high. Ready is low only while the power sequence is incomplete; it does not drop while programming is busy, and a write taken in that state is discarded. A read response appears for exactly one cycle, the cycle after the request is taken. The response has no back-pressure, so the consumer must take it in that cycle. The stop input is a one-cycle pulse that marks the end of a transaction.

Top module: `wiper_bank`

## Requirements
- R1: Address map. 0 is wiper 0, 1 is wiper 1, 2 to 6 are general-purpose bytes (reset 00h), 7 is reserved, 8 is control. Addresses 7 and 9 to 15 read 00h and ignore writes.
- R2: When control bit 7 (mode) is 1, a write to address 0 or 1 changes only the volatile wiper code, and a read of address 0 or 1 returns that code. In this mode addresses 2 to 6 read 00h and ignore writes.
- R3: When the mode bit is 0, a read of address 0 or 1 returns the committed initial value (reset 40h). A write there sets the wiper code in the same edge, and the initial value becomes readable only after the programming cycle that follows stop.
- R4: Control reads as {mode, shutdown-enable, busy, 00000b} and resets to 40h. Bit 5 (busy) cannot be written, and bits 4 to 0 always read 0.
- R5: Both shutdown flags are high unless control bit 6 and the shutdown pin are both 1. Wiper codes are unchanged by entering or leaving shutdown, and writes still act during shutdown.
- R6: A stop pulse with a pending non-volatile byte sets busy from the next cycle for PROG_CYC cycles, then commits the byte. A stop pulse with nothing pending leaves busy at 0.
- R7: Only the first non-volatile byte written in a transaction is pending. Later non-volatile writes in the same transaction have no effect, which includes the wiper code.
- R8: While busy, every accepted write is discarded, including writes to control.
- R9: While power-good is low, both wipers are 40h, control returns to 40h, and ready is low. Within two cycles of power-good rising, the wipers hold their initial values and ready is high. Non-volatile contents survive this cycle.
- R10: A read response is valid only in the cycle after an accepted request. It carries the state as it was at that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; also loads non-volatile defaults |
| pwr_good | input | 1 | Supply adequate for recall |
| shut_pin | input | 1 | Shutdown pin, 0 forces shutdown |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request ready |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_addr | input | 4 | Read address |
| rd_rsp_valid | output | 1 | Read response valid (one cycle) |
| rd_rsp_data | output | 8 | Read response byte |
| txn_stop | input | 1 | One-cycle end-of-transaction pulse |
| wiper0 | output | 7 | Wiper 0 code, 00h nearest ground |
| wiper1 | output | 7 | Wiper 1 code, 00h nearest ground |
| shdn0 | output | 1 | Channel 0 shutdown flag |
| shdn1 | output | 1 | Channel 1 shutdown flag |

## Verification
The assertions rely on two things. First, txn_stop is a single-cycle pulse and is never high in the same cycle as an accepted write. Second, reset is held low from time zero until the inputs are driven to known values. The bench changes every input on the falling clock edge and raises txn_stop only in a cycle of its own, after the writes of a transaction. It makes writes during programming only to check that they are discarded. Power-good is dropped only while no transaction is in progress.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    PS_OFF    = 2'd0,
    PS_RECALL = 2'd1,
    PS_RUN    = 2'd2
  } pwr_state_e;

  typedef enum logic [2:0] {
    AK_WIPER = 3'd0,
    AK_GP    = 3'd1,
    AK_CTRL  = 3'd2,
    AK_NONE  = 3'd3
  } addr_kind_e;

  function automatic addr_kind_e classify(input logic [3:0] a, input int nch, input int ngp);
    if (int'(a) < nch)             return AK_WIPER;
    else if (int'(a) < nch + ngp)  return AK_GP;
    else if (int'(a) == nch + ngp + 1) return AK_CTRL;
    else                           return AK_NONE;
  endfunction
endpackage

// File: rtl/wb_nv_store.sv
module wb_nv_store #(
  parameter int NCH      = 2,
  parameter int NGP      = 5,
  parameter int PROG_CYC = 32,
  parameter logic [7:0] MID = 8'h40,
  parameter int AW       = 4,
  localparam int DEPTH   = NCH + NGP,
  localparam int IW      = $clog2(DEPTH),
  localparam int TW      = $clog2(PROG_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                drop_pend,
  input  logic                nv_wr,
  input  logic [IW-1:0]       nv_idx,
  input  logic [7:0]          nv_data,
  input  logic                stop,
  output logic                busy,
  output logic                pend_full,
  input  logic [AW-1:0]       rd_idx,
  output logic [7:0]          rd_byte,
  output logic [NCH-1:0][7:0] ivr
);
  logic [7:0]    mem [DEPTH];
  logic          pend_v;
  logic [IW-1:0] pend_idx, cmt_idx;
  logic [7:0]    pend_data, cmt_data;
  logic [TW-1:0] timer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= (i < NCH) ? MID : 8'h00;
      pend_v    <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
      cmt_idx   <= '0;
      cmt_data  <= '0;
      busy      <= 1'b0;
      timer     <= '0;
    end else begin
      if (drop_pend) begin
        pend_v <= 1'b0;
      end else if (nv_wr && !pend_v) begin
        pend_v    <= 1'b1;
        pend_idx  <= nv_idx;
        pend_data <= nv_data;
      end
      if (stop && pend_v && !busy && !drop_pend) begin
        busy     <= 1'b1;
        timer    <= TW'(PROG_CYC - 1);
        cmt_idx  <= pend_idx;
        cmt_data <= pend_data;
        pend_v   <= 1'b0;
      end else if (busy) begin
        if (timer == '0) begin
          mem[cmt_idx] <= cmt_data;
          busy         <= 1'b0;
        end else begin
          timer <= timer - 1'b1;
        end
      end
    end
  end

  assign pend_full = pend_v;
  assign rd_byte   = (int'(rd_idx) < DEPTH) ? mem[rd_idx[IW-1:0]] : 8'h00;

  for (genvar g = 0; g < NCH; g++) begin : g_ivr
    assign ivr[g] = mem[g];
  end

  // R6: programming starts only from a stop pulse
  a_r6_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop));
  // R6: programming runs until its count is used up
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && timer != '0) |=> busy);
  // R8: the write path never offers a byte during programming
  a_r8_no_nv_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr |-> !busy);
endmodule

// File: rtl/wb_pwr_seq.sv
module wb_pwr_seq
  import wb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic preset,
  output logic recall,
  output logic up
);
  pwr_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PS_OFF;
    else begin
      unique case (st)
        PS_OFF:    if (pwr_good) st <= PS_RECALL;
        PS_RECALL: st <= pwr_good ? PS_RUN : PS_OFF;
        PS_RUN:    if (!pwr_good) st <= PS_OFF;
        default:   st <= PS_OFF;
      endcase
    end
  end

  assign preset = (st == PS_OFF);
  assign recall = (st == PS_RECALL);
  assign up     = (st == PS_RUN);

  // R9: recall is a single cycle, never repeated back to back
  a_r9_recall_single: assert property (@(posedge clk) disable iff (!rst_n)
    recall |=> !recall);
  // R9: ports open only after a recall
  a_r9_up_after_recall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up) |-> $past(recall));
endmodule

// File: rtl/wb_wiper_regs.sv
module wb_wiper_regs #(
  parameter int NCH = 2,
  parameter int W   = 7,
  parameter logic [W-1:0] MID = 7'h40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                preset,
  input  logic                recall,
  input  logic [NCH-1:0][W-1:0] ivr_code,
  input  logic                code_wr,
  input  logic [$clog2(NCH)-1:0] code_ch,
  input  logic [W-1:0]        code_val,
  input  logic                ctrl_wr,
  input  logic [1:0]          ctrl_val,
  output logic [NCH-1:0][W-1:0] code,
  output logic                vol,
  output logic                sden
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          code[g] <= MID;
      else if (preset)                     code[g] <= MID;
      else if (recall)                     code[g] <= ivr_code[g];
      else if (code_wr && int'(code_ch) == g) code[g] <= code_val;
    end

    // R9: while supply is not good, the code sits at mid-scale
    a_r9_preset_mid: assert property (@(posedge clk) disable iff (!rst_n)
      preset |=> (code[g] == MID));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || preset) begin
      vol  <= 1'b0;
      sden <= 1'b1;
    end else if (ctrl_wr) begin
      vol  <= ctrl_val[1];
      sden <= ctrl_val[0];
    end
  end

  // R4: control returns to its power-on value during power-up
  a_r4_ctrl_preset: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (!vol && sden));
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wb_pkg::*;
#(
  parameter int WIPER_W  = 7,
  parameter int NGP      = 5,
  parameter int PROG_CYC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_good,
  input  logic               shut_pin,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [3:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               rd_valid,
  output logic               rd_ready,
  input  logic [3:0]         rd_addr,
  output logic               rd_rsp_valid,
  output logic [7:0]         rd_rsp_data,
  input  logic               txn_stop,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1,
  output logic               shdn0,
  output logic               shdn1
);
  localparam int NCH   = 2;
  localparam int DEPTH = NCH + NGP;
  localparam int IW    = $clog2(DEPTH);
  localparam int CW    = $clog2(NCH);
  localparam logic [7:0]         MID_B = 8'h40;
  localparam logic [WIPER_W-1:0] MID_C = WIPER_W'(64);

  logic preset, recall, up;
  logic busy, pend_full, vol, sden;
  logic [NCH-1:0][7:0]         ivr;
  logic [NCH-1:0][WIPER_W-1:0] ivr_code, code;
  logic [7:0] nv_byte;
  addr_kind_e wk, rk;
  logic wr_fire, rd_fire, nv_wr, code_wr, ctrl_wr;

  wb_pwr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .preset(preset), .recall(recall), .up(up)
  );

  assign wr_ready = up;
  assign rd_ready = up;
  assign wk       = classify(wr_addr, NCH, NGP);
  assign rk       = classify(rd_addr, NCH, NGP);
  assign wr_fire  = wr_valid && up && !busy;
  assign rd_fire  = rd_valid && up;
  assign nv_wr    = wr_fire && !vol && (wk == AK_WIPER || wk == AK_GP);
  assign code_wr  = wr_fire && (wk == AK_WIPER) && (vol || !pend_full);
  assign ctrl_wr  = wr_fire && (wk == AK_CTRL);

  wb_nv_store #(
    .NCH(NCH), .NGP(NGP), .PROG_CYC(PROG_CYC), .MID(MID_B), .AW(4)
  ) u_nv (
    .clk(clk), .rst_n(rst_n), .drop_pend(!up),
    .nv_wr(nv_wr), .nv_idx(wr_addr[IW-1:0]), .nv_data(wr_data),
    .stop(txn_stop), .busy(busy), .pend_full(pend_full),
    .rd_idx(rd_addr), .rd_byte(nv_byte), .ivr(ivr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ivr
    assign ivr_code[g] = ivr[g][WIPER_W-1:0];
  end

  wb_wiper_regs #(.NCH(NCH), .W(WIPER_W), .MID(MID_C)) u_regs (
    .clk(clk), .rst_n(rst_n), .preset(preset), .recall(recall),
    .ivr_code(ivr_code), .code_wr(code_wr), .code_ch(wr_addr[CW-1:0]),
    .code_val(wr_data[WIPER_W-1:0]), .ctrl_wr(ctrl_wr),
    .ctrl_val(wr_data[7:6]), .code(code), .vol(vol), .sden(sden)
  );

  logic unused_bits;
  assign unused_bits = ^{ivr[0][7:WIPER_W], ivr[1][7:WIPER_W]};

  // read path: one registered stage
  logic [7:0] rd_mux;
  always_comb begin
    unique case (rk)
      AK_WIPER: rd_mux = vol ? 8'(code[rd_addr[CW-1:0]]) : nv_byte;
      AK_GP:    rd_mux = vol ? 8'h00 : nv_byte;
      AK_CTRL:  rd_mux = {vol, sden, busy, 5'b0};
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= 8'h00;
    end else begin
      rd_rsp_valid <= rd_fire;
      if (rd_fire) rd_rsp_data <= rd_mux;
    end
  end

  assign wiper0 = code[0];
  assign wiper1 = code[1];
  assign shdn0  = !(sden && shut_pin);
  assign shdn1  = !(sden && shut_pin);

  // R10: a response only follows an accepted request
  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid |-> $past(rd_valid && rd_ready));
  // R5: a low shutdown pin puts both channels in shutdown
  a_r5_pin_forces_shdn: assert property (@(posedge clk) disable iff (!rst_n)
    !shut_pin |-> (shdn0 && shdn1));
  // R8: wiper codes do not move while programming, outside a power sequence
  a_r8_codes_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && up && $past(up)) |-> ($stable(wiper0) && $stable(wiper1)));
  // R9: ports are closed until the supply is good
  a_r9_ready_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> $past(pwr_good));
endmodule

// File: tb/wiper_bank_tb.sv
module wiper_bank_tb;
  localparam int PROG = 32;

  logic clk = 1'b0;
  logic rst_n, pwr_good, shut_pin, wr_valid, rd_valid, txn_stop;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_rsp_data;
  logic wr_ready, rd_ready, rd_rsp_valid, shdn0, shdn1;
  logic [6:0] wiper0, wiper1;
  int total = 0;
  int bad = 0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  wiper_bank #(.WIPER_W(7), .NGP(5), .PROG_CYC(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .shut_pin(shut_pin),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .txn_stop(txn_stop),
    .wiper0(wiper0), .wiper1(wiper1), .shdn0(shdn0), .shdn1(shdn1)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rd_rsp_valid === 1'b1, "R10 response valid", {7'b0, rd_rsp_valid}, 8'h01);
    d = rd_rsp_data;
    @(negedge clk);
    chk(rd_rsp_valid === 1'b0, "R10 response single cycle", {7'b0, rd_rsp_valid}, 8'h00);
  endtask

  task automatic stop_pulse();
    @(negedge clk);
    txn_stop = 1'b1;
    @(negedge clk);
    txn_stop = 1'b0;
  endtask

  task automatic wait_prog();
    repeat (PROG + 4) @(negedge clk);
  endtask

  task automatic t_reset_and_powerup();
    rst_n = 1'b0; pwr_good = 1'b0; shut_pin = 1'b1;
    wr_valid = 1'b0; rd_valid = 1'b0; txn_stop = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(wiper0 == 7'h40, "R9 wiper0 mid before power", {1'b0, wiper0}, 8'h40);
    chk(wr_ready == 1'b0, "R9 ready low before power", {7'b0, wr_ready}, 8'h00);
    pwr_good = 1'b1;
    repeat (3) @(negedge clk);
    chk(wr_ready && rd_ready, "R9 ready after power", {7'b0, wr_ready}, 8'h01);
    chk(wiper1 == 7'h40, "R9 wiper1 default recall", {1'b0, wiper1}, 8'h40);
    rd(4'd8, got);
    chk(got == 8'h40, "R4 control reset", got, 8'h40);
  endtask

  task automatic t_nv_write();
    wr(4'd0, 8'h15);
    chk(wiper0 == 7'h15, "R3 wiper follows initial-value write", {1'b0, wiper0}, 8'h15);
    rd(4'd0, got);
    chk(got == 8'h40, "R3 initial value not yet committed", got, 8'h40);
    stop_pulse();
    rd(4'd8, got);
    chk(got == 8'h60, "R6 busy after stop", got, 8'h60);
    wait_prog();
    rd(4'd8, got);
    chk(got == 8'h40, "R6 busy cleared", got, 8'h40);
    rd(4'd0, got);
    chk(got == 8'h15, "R6 committed value", got, 8'h15);
  endtask

  task automatic t_burst_drop();
    wr(4'd1, 8'h22);
    wr(4'd2, 8'h33);
    chk(wiper1 == 7'h22, "R7 first byte reaches wiper1", {1'b0, wiper1}, 8'h22);
    stop_pulse();
    wait_prog();
    rd(4'd2, got);
    chk(got == 8'h00, "R7 second byte dropped", got, 8'h00);
    rd(4'd1, got);
    chk(got == 8'h22, "R7 first byte committed", got, 8'h22);
    wr(4'd3, 8'h5A);
    wr(4'd0, 8'h11);
    chk(wiper0 == 7'h15, "R7 dropped byte leaves wiper0", {1'b0, wiper0}, 8'h15);
    stop_pulse();
    wait_prog();
    rd(4'd3, got);
    chk(got == 8'h5A, "R7 general byte committed", got, 8'h5A);
    rd(4'd0, got);
    chk(got == 8'h15, "R7 initial value 0 unchanged", got, 8'h15);
  endtask

  task automatic t_busy_lock();
    wr(4'd4, 8'h77);
    stop_pulse();
    wr(4'd8, 8'h80);
    wr(4'd0, 8'h01);
    chk(wiper0 == 7'h15, "R8 wiper write refused", {1'b0, wiper0}, 8'h15);
    rd(4'd8, got);
    chk(got == 8'h60, "R8 control write refused", got, 8'h60);
    wait_prog();
    rd(4'd8, got);
    chk(got == 8'h40, "R8 control unchanged after busy", got, 8'h40);
    rd(4'd4, got);
    chk(got == 8'h77, "R8 pending byte committed", got, 8'h77);
  endtask

  task automatic t_vol_mode();
    wr(4'd8, 8'h80);
    rd(4'd8, got);
    chk(got == 8'h80, "R2 mode bit set", got, 8'h80);
    wr(4'd0, 8'h7F);
    chk(wiper0 == 7'h7F, "R2 volatile write", {1'b0, wiper0}, 8'h7F);
    stop_pulse();
    rd(4'd8, got);
    chk(got == 8'h80, "R6 stop with nothing pending", got, 8'h80);
    rd(4'd0, got);
    chk(got == 8'h7F, "R2 reads wiper code", got, 8'h7F);
    rd(4'd4, got);
    chk(got == 8'h00, "R2 general byte hidden", got, 8'h00);
    wr(4'd4, 8'h01);
    stop_pulse();
    wr(4'd8, 8'h40);
    rd(4'd0, got);
    chk(got == 8'h15, "R2 initial value untouched", got, 8'h15);
    rd(4'd4, got);
    chk(got == 8'h77, "R2 general write ignored", got, 8'h77);
    wr(4'd8, 8'hDF);
    rd(4'd8, got);
    chk(got == 8'hC0, "R4 read-only and unused bits", got, 8'hC0);
    wr(4'd8, 8'h40);
  endtask

  task automatic t_map();
    rd(4'd7, got);
    chk(got == 8'h00, "R1 reserved reads zero", got, 8'h00);
    wr(4'd7, 8'hAA);
    stop_pulse();
    rd(4'd7, got);
    chk(got == 8'h00, "R1 reserved ignores write", got, 8'h00);
    rd(4'd12, got);
    chk(got == 8'h00, "R1 unmapped reads zero", got, 8'h00);
    wr(4'd6, 8'h3C);
    stop_pulse();
    wait_prog();
    rd(4'd6, got);
    chk(got == 8'h3C, "R1 last general byte", got, 8'h3C);
  endtask

  task automatic t_shutdown();
    @(negedge clk);
    shut_pin = 1'b0;
    @(negedge clk);
    chk(shdn0 && shdn1, "R5 pin shutdown", {6'b0, shdn1, shdn0}, 8'h03);
    chk(wiper0 == 7'h7F, "R5 code kept in shutdown", {1'b0, wiper0}, 8'h7F);
    wr(4'd8, 8'hC0);
    wr(4'd1, 8'h05);
    chk(wiper1 == 7'h05, "R5 write during shutdown", {1'b0, wiper1}, 8'h05);
    shut_pin = 1'b1;
    @(negedge clk);
    chk(!shdn0 && !shdn1, "R5 pin release", {6'b0, shdn1, shdn0}, 8'h00);
    wr(4'd8, 8'h80);
    chk(shdn0 && shdn1, "R5 control bit shutdown", {6'b0, shdn1, shdn0}, 8'h03);
    wr(4'd8, 8'h40);
    chk(!shdn0 && wiper1 == 7'h05, "R5 resume same code", {1'b0, wiper1}, 8'h05);
  endtask

  task automatic t_power_cycle();
    @(negedge clk);
    pwr_good = 1'b0;
    repeat (3) @(negedge clk);
    chk(wiper0 == 7'h40 && wiper1 == 7'h40, "R9 mid-scale on power loss", {1'b0, wiper0}, 8'h40);
    chk(!wr_ready && !rd_ready, "R9 ready low on power loss", {7'b0, wr_ready}, 8'h00);
    pwr_good = 1'b1;
    repeat (3) @(negedge clk);
    chk(wiper0 == 7'h15, "R9 recall wiper0", {1'b0, wiper0}, 8'h15);
    chk(wiper1 == 7'h22, "R9 recall wiper1", {1'b0, wiper1}, 8'h22);
    rd(4'd8, got);
    chk(got == 8'h40, "R9 control back to reset", got, 8'h40);
    rd(4'd6, got);
    chk(got == 8'h3C, "R9 storage survives", got, 8'h3C);
  endtask

  initial begin
    t_reset_and_powerup();
    t_nv_write();
    t_burst_drop();
    t_busy_lock();
    t_vol_mode();
    t_map();
    t_shutdown();
    t_power_cycle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule